// File: doc/BRIEF.md
# 18-bit Parallel LCD Bus Master

This block is a bus master for a panel controller that sits on an 8080-style parallel bus. The panel's 16-bit registers are reached through an 18-bit data lane whose bit layout is fixed. Two lane bits are always driven high. The low byte of a word sits one position up from the bottom and the high byte sits two positions up. The block performs this remapping on every value it drives. On reads it takes the word back out of the lane and drops the two forced bits.

A host issues one command at a time through a request/acknowledge port. It places the command, a register number and a write value on the port and raises `host_req`. It keeps the request high until `host_done` pulses. Three commands are supported:

- A full register write: an index cycle followed by a data write cycle.
- A register read: an index cycle followed by a data read cycle.
- A short write: one index cycle that packs the register number and an 8-bit value together.

The block generates chip-select, register-select, write strobe, read strobe and the lane's output enable. The strobe low time and the recovery time are set by parameters.

Top module: `lcd18_bus_master`

## Requirements
- R1: On `lcd_dout`, word bits 7..0 appear on lane bits 8..1 and lane bit 0 is 1.
- R2: On `lcd_dout`, word bits 15..8 appear on lane bits 17..10 and lane bit 9 is 1.
- R3: A read returns `{lcd_din[17:10], lcd_din[8:1]}` on `host_rdata`. The values of lane bits 0 and 9 have no effect on the result.
- R4: Command 2'b00 (full write) gives exactly two write strobes. The first has `lcd_rs`=0 and carries `host_addr`. The second has `lcd_rs`=1 and carries `host_wdata`. Code 2'b11 behaves the same as 2'b00.
- R5: Command 2'b01 (read) gives one write strobe with `lcd_rs`=0 carrying `host_addr`. It is followed by one read strobe with `lcd_rs`=1, and no write strobe occurs in that phase.
- R6: Command 2'b10 (short write) gives exactly one write strobe with `lcd_rs`=0 carrying the word `{host_addr[7:0], host_wdata[7:0]}`.
- R7: `lcd_cs_n` is low across every strobe of a command and high when the block is idle. Strobes occur only while `lcd_cs_n` is low.
- R8: Each strobe stays low for exactly STROBE_CYC cycles. Two strobes of one command are separated by exactly RECOV_CYC high cycles. Done follows the final strobe after RECOV_CYC more cycles.
- R9: `lcd_oe` is low for the whole read strobe and high during every write strobe. The write and read strobes are never low together.
- R10: `host_done` is a one-cycle pulse, and `host_rdata` is valid while it is high. `host_ready` is low from acceptance until after the done pulse.
- R11: After reset: `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are 1, `host_done` is 0 and `host_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Command request, held until done |
| host_cmd | input | 2 | 00 write, 01 read, 10 short write, 11 as write |
| host_addr | input | 16 | Register number (short write uses bits 7..0) |
| host_wdata | input | 16 | Write value (short write uses bits 7..0) |
| host_ready | output | 1 | Block idle and able to accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read result, valid with done |
| lcd_cs_n | output | 1 | Panel chip-select, active low |
| lcd_rs | output | 1 | Register-select: 0 index phase, 1 data phase |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_oe | output | 1 | Lane output enable (1 drives `lcd_dout`) |
| lcd_dout | output | 18 | Outgoing remapped lane |
| lcd_din | input | 18 | Incoming lane |

## Verification
The assertions assume that the host keeps `host_req` and its command fields steady until the done pulse. They also assume that a new request is raised only while `host_ready` is high, so every command runs as one uninterrupted sequence of strobes. The bench follows this rule. Each scenario task raises the request on a falling edge, holds it unchanged, and drops it on the falling edge where it sees done. The bench drives `lcd_din` with stable panel data for the whole command. It sets lane bits 0 and 9 to zero so that any leak of those bits into the read result is visible.

// File: rtl/lcdbus_pkg.sv
package lcdbus_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANE_W = WORD_W + 2;

  typedef enum logic [1:0] {
    LB_WRITE = 2'b00,
    LB_READ  = 2'b01,
    LB_SHORT = 2'b10,
    LB_RSVD  = 2'b11
  } lb_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STROBE,
    ST_RECOVER
  } lb_state_e;
endpackage

// File: rtl/lcdbus_lane_pack.sv
module lcdbus_lane_pack
  import lcdbus_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int HI_BASE = BYTE_W + 2;

  always_comb begin
    lane_o                              = '0;
    lane_o[0]                           = 1'b1;
    lane_o[BYTE_W+1]                    = 1'b1;
    lane_o[BYTE_W:1]                    = word_i[BYTE_W-1:0];
    lane_o[HI_BASE+BYTE_W-1:HI_BASE]    = word_i[WORD_W-1:BYTE_W];
  end
endmodule

// File: rtl/lcdbus_lane_unpack.sv
module lcdbus_lane_unpack
  import lcdbus_pkg::*;
(
  input  logic [WORD_W-1:0] lane_bytes_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = lane_bytes_i;
  end
endmodule

// File: rtl/lcdbus_timer.sv
module lcdbus_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lcdbus_seq.sv
module lcdbus_seq
  import lcdbus_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        cmd_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] payload_o,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              cs_n_o,
  output logic              rs_o,
  output logic              wr_n_o,
  output logic              rd_n_o,
  output logic              oe_o,
  output logic [LANE_W-1:0] dout_o
);
  localparam int MAX_CYC = (STROBE_CYC > RECOV_CYC) ? STROBE_CYC : RECOV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] STB_LOAD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECOV_CYC - 1);

  lb_state_e         state_q, state_d;
  lb_cmd_e           cmd_q, cmd_d, cmd_in;
  logic              data_ph_q, data_ph_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              done_q, done_d;
  logic              cs_n_q, cs_n_d;
  logic              rs_q, rs_d;
  logic              wr_n_q, wr_n_d;
  logic              rd_n_q, rd_n_d;
  logic              oe_q, oe_d;
  logic [LANE_W-1:0] dout_q, dout_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_zero;

  lcdbus_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign cmd_in  = lb_cmd_e'(cmd_i);
  assign ready_o = (state_q == ST_IDLE) && !done_q;

  // word presented to the packer for the next phase to start
  always_comb begin
    if (state_q == ST_IDLE)
      payload_o = (cmd_in == LB_SHORT) ? {addr_i[BYTE_W-1:0], wdata_i[BYTE_W-1:0]}
                                       : addr_i;
    else
      payload_o = wdata_q;
  end

  always_comb begin
    state_d   = state_q;
    cmd_d     = cmd_q;
    data_ph_d = data_ph_q;
    wdata_d   = wdata_q;
    rdata_d   = rdata_q;
    done_d    = 1'b0;
    cs_n_d    = cs_n_q;
    rs_d      = rs_q;
    wr_n_d    = wr_n_q;
    rd_n_d    = rd_n_q;
    oe_d      = oe_q;
    dout_d    = dout_q;
    tmr_load  = 1'b0;
    tmr_val   = STB_LOAD;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && !done_q) begin
          cmd_d     = cmd_in;
          wdata_d   = wdata_i;
          data_ph_d = 1'b0;
          cs_n_d    = 1'b0;
          rs_d      = 1'b0;
          wr_n_d    = 1'b0;
          oe_d      = 1'b1;
          dout_d    = lane_i;
          tmr_load  = 1'b1;
          tmr_val   = STB_LOAD;
          state_d   = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          if (!rd_n_q) rdata_d = rd_word_i;
          wr_n_d   = 1'b1;
          rd_n_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = REC_LOAD;
          state_d  = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (tmr_zero) begin
          if (!data_ph_q && (cmd_q != LB_SHORT)) begin
            data_ph_d = 1'b1;
            rs_d      = 1'b1;
            if (cmd_q == LB_READ) begin
              rd_n_d = 1'b0;
              oe_d   = 1'b0;
            end else begin
              wr_n_d = 1'b0;
              dout_d = lane_i;
            end
            tmr_load = 1'b1;
            tmr_val  = STB_LOAD;
            state_d  = ST_STROBE;
          end else begin
            data_ph_d = 1'b0;
            cs_n_d    = 1'b1;
            oe_d      = 1'b1;
            done_d    = 1'b1;
            state_d   = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= LB_WRITE;
      data_ph_q <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      rs_q      <= 1'b1;
      wr_n_q    <= 1'b1;
      rd_n_q    <= 1'b1;
      oe_q      <= 1'b1;
      dout_q    <= LANE_W'(1) | (LANE_W'(1) << (BYTE_W + 1));
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      data_ph_q <= data_ph_d;
      wdata_q   <= wdata_d;
      rdata_q   <= rdata_d;
      done_q    <= done_d;
      cs_n_q    <= cs_n_d;
      rs_q      <= rs_d;
      wr_n_q    <= wr_n_d;
      rd_n_q    <= rd_n_d;
      oe_q      <= oe_d;
      dout_q    <= dout_d;
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign cs_n_o  = cs_n_q;
  assign rs_o    = rs_q;
  assign wr_n_o  = wr_n_q;
  assign rd_n_o  = rd_n_q;
  assign oe_o    = oe_q;
  assign dout_o  = dout_q;
endmodule

// File: rtl/lcd18_bus_master.sv
module lcd18_bus_master
  import lcdbus_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [1:0]        host_cmd,
  input  logic [WORD_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [WORD_W-1:0] host_rdata,
  output logic              lcd_cs_n,
  output logic              lcd_rs,
  output logic              lcd_wr_n,
  output logic              lcd_rd_n,
  output logic              lcd_oe,
  output logic [LANE_W-1:0] lcd_dout,
  input  logic [LANE_W-1:0] lcd_din
);
  localparam int HI_BASE = BYTE_W + 2;

  logic [WORD_W-1:0] payload;
  logic [LANE_W-1:0] payload_lane;
  logic [WORD_W-1:0] rd_word;
  logic              unused_forced_bits;

  assign unused_forced_bits = ^{lcd_din[BYTE_W+1], lcd_din[0]};

  lcdbus_lane_pack u_pack (
    .word_i (payload),
    .lane_o (payload_lane)
  );

  lcdbus_lane_unpack u_unpack (
    .lane_bytes_i ({lcd_din[HI_BASE+BYTE_W-1:HI_BASE], lcd_din[BYTE_W:1]}),
    .word_o       (rd_word)
  );

  lcdbus_seq #(
    .STROBE_CYC (STROBE_CYC),
    .RECOV_CYC  (RECOV_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (host_req),
    .cmd_i     (host_cmd),
    .addr_i    (host_addr),
    .wdata_i   (host_wdata),
    .ready_o   (host_ready),
    .done_o    (host_done),
    .rdata_o   (host_rdata),
    .payload_o (payload),
    .lane_i    (payload_lane),
    .rd_word_i (rd_word),
    .cs_n_o    (lcd_cs_n),
    .rs_o      (lcd_rs),
    .wr_n_o    (lcd_wr_n),
    .rd_n_o    (lcd_rd_n),
    .oe_o      (lcd_oe),
    .dout_o    (lcd_dout)
  );
endmodule

// File: rtl/lcdbus_checker.sv
module lcdbus_checker
  import lcdbus_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int RECOV_CYC  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_done,
  input logic              lcd_cs_n,
  input logic              lcd_rs,
  input logic              lcd_wr_n,
  input logic              lcd_rd_n,
  input logic              lcd_oe,
  input logic [LANE_W-1:0] lcd_dout
);
  logic [15:0] low_cnt;
  logic [15:0] high_cnt;
  logic        any_low;

  assign any_low = !lcd_wr_n || !lcd_rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else begin
      low_cnt  <= any_low ? low_cnt + 16'd1 : 16'd0;
      high_cnt <= (lcd_cs_n || any_low) ? 16'd0 : high_cnt + 16'd1;
    end
  end

  AST_LANE_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_dout[0] && lcd_dout[BYTE_W+1]); // R1
  AST_READ_IN_DATA_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> lcd_rs); // R5
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> !lcd_cs_n); // R7
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_wr_n) || $rose(lcd_rd_n)) |-> (low_cnt == 16'(STROBE_CYC))); // R8
  AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(lcd_wr_n) || $fell(lcd_rd_n)) && $past(!lcd_cs_n)) |-> (high_cnt == 16'(RECOV_CYC))); // R8
  AST_READ_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> !lcd_oe); // R9
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> lcd_oe); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lcd_wr_n && !lcd_rd_n)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs_n |-> !host_ready); // R10
endmodule

bind lcd18_bus_master lcdbus_checker #(
  .STROBE_CYC (STROBE_CYC),
  .RECOV_CYC  (RECOV_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .host_done  (host_done),
  .lcd_cs_n   (lcd_cs_n),
  .lcd_rs     (lcd_rs),
  .lcd_wr_n   (lcd_wr_n),
  .lcd_rd_n   (lcd_rd_n),
  .lcd_oe     (lcd_oe),
  .lcd_dout   (lcd_dout)
);

// File: tb/lcd18_bus_master_tb.sv
module lcd18_bus_master_tb;
  localparam int S = 3;
  localparam int R = 2;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic [1:0]  host_cmd;
  logic [15:0] host_addr, host_wdata;
  logic        host_ready, host_done;
  logic [15:0] host_rdata;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_oe;
  logic [17:0] lcd_dout, lcd_din;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // per-command capture
  int          ev_n;
  logic        ev_rs   [4];
  logic        ev_rd   [4];
  logic        ev_oe   [4];
  logic [17:0] ev_lane [4];
  int          ev_w    [4];
  int          gap;
  int          cyc;
  int          bad_cs, bad_ready, bad_oe;
  logic [15:0] got_rdata;

  lcd18_bus_master #(.STROBE_CYC(S), .RECOV_CYC(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_cmd(host_cmd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .lcd_cs_n(lcd_cs_n),
    .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_oe(lcd_oe),
    .lcd_dout(lcd_dout), .lcd_din(lcd_din)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [17:0] lane(input logic [15:0] v);
    return {v[15:8], 1'b1, v[7:0], 1'b1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [15:0] a,
                         input logic [15:0] w, input logic [15:0] panel);
    bit prev_lo;
    int hi;
    @(negedge clk);
    lcd_din    = {panel[15:8], 1'b0, panel[7:0], 1'b0};
    host_cmd   = c;
    host_addr  = a;
    host_wdata = w;
    host_req   = 1'b1;
    ev_n = 0; gap = -1; cyc = 0; hi = 0; prev_lo = 0;
    bad_cs = 0; bad_ready = 0; bad_oe = 0;
    for (int k = 0; k < 100; k++) begin
      bit lo;
      @(negedge clk);
      cyc++;
      lo = !lcd_wr_n || !lcd_rd_n;
      if (host_ready && !host_done) bad_ready++;
      if (lo) begin
        if (lcd_cs_n) bad_cs++;
        if (!lcd_rd_n && lcd_oe) bad_oe++;
        if (!lcd_wr_n && (!lcd_oe || !lcd_rd_n)) bad_oe++;
        if (!prev_lo) begin
          if (ev_n > 0) gap = hi;
          if (ev_n < 4) begin
            ev_rs[ev_n] = lcd_rs; ev_rd[ev_n] = !lcd_rd_n;
            ev_oe[ev_n] = lcd_oe; ev_lane[ev_n] = lcd_dout; ev_w[ev_n] = 0;
          end
          ev_n++;
        end
        if (ev_n <= 4) ev_w[ev_n-1]++;
        hi = 0;
      end else begin
        hi++;
      end
      prev_lo = lo;
      if (host_done) begin
        got_rdata = host_rdata;
        host_req = 1'b0;
        break;
      end
    end
    @(negedge clk);
    chk("R7 cs_n high after command", 32'(lcd_cs_n), 32'd1);
    chk("R10 done lasts one cycle", 32'(host_done), 32'd0);
    chk("R10 ready after command", 32'(host_ready), 32'd1);
    chk("R7 strobes under cs_n", 32'(bad_cs), 32'd0);
    chk("R10 ready low while busy", 32'(bad_ready), 32'd0);
    chk("R9 output enable per strobe", 32'(bad_oe), 32'd0);
  endtask

  task automatic test_reset;
    chk("R11 cs_n at reset", 32'(lcd_cs_n), 32'd1);
    chk("R11 wr_n at reset", 32'(lcd_wr_n), 32'd1);
    chk("R11 rd_n at reset", 32'(lcd_rd_n), 32'd1);
    chk("R11 done at reset", 32'(host_done), 32'd0);
    chk("R11 ready at reset", 32'(host_ready), 32'd1);
  endtask

  task automatic test_write(input logic [1:0] c, input logic [15:0] a, input logic [15:0] w);
    run_cmd(c, a, w, 16'h0000);
    chk("R4 strobe count", 32'(ev_n), 32'd2);
    chk("R4 index rs", 32'(ev_rs[0]), 32'd0);
    chk("R4 data rs", 32'(ev_rs[1]), 32'd1);
    chk("R4 no read strobe", 32'({ev_rd[0], ev_rd[1]}), 32'd0);
    chk("R1 R2 index lane", 32'(ev_lane[0]), 32'(lane(a)));
    chk("R1 R2 data lane", 32'(ev_lane[1]), 32'(lane(w)));
    chk("R8 strobe widths", 32'({ev_w[0][15:0], ev_w[1][15:0]}), {16'(S), 16'(S)});
    chk("R8 recovery gap", 32'(gap), 32'(R));
    chk("R8 write command length", 32'(cyc), 32'(2*(S+R)+1));
  endtask

  task automatic test_read(input logic [15:0] a, input logic [15:0] panel);
    run_cmd(2'b01, a, 16'hFFFF, panel);
    chk("R5 strobe count", 32'(ev_n), 32'd2);
    chk("R5 index is write rs0", 32'({ev_rd[0], ev_rs[0]}), 32'd0);
    chk("R5 index lane", 32'(ev_lane[0]), 32'(lane(a)));
    chk("R5 data is read rs1", 32'({ev_rd[1], ev_rs[1]}), 32'd3);
    chk("R9 oe low on read", 32'(ev_oe[1]), 32'd0);
    chk("R8 read strobe width", 32'(ev_w[1]), 32'(S));
    chk("R3 read data", 32'(got_rdata), 32'(panel));
  endtask

  task automatic test_short(input logic [15:0] a, input logic [15:0] w);
    run_cmd(2'b10, a, w, 16'h0000);
    chk("R6 single strobe", 32'(ev_n), 32'd1);
    chk("R6 rs index, write", 32'({ev_rd[0], ev_rs[0]}), 32'd0);
    chk("R6 packed lane", 32'(ev_lane[0]), 32'(lane({a[7:0], w[7:0]})));
    chk("R8 short command length", 32'(cyc), 32'(S+R+1));
  endtask

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_cmd = '0; host_addr = '0;
    host_wdata = '0; lcd_din = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_write(2'b00, 16'h0050, 16'h1234);
    test_write(2'b00, 16'hFF00, 16'h00FF);
    test_write(2'b11, 16'h0021, 16'hA5C3);   // R4 code 11 acts as write
    test_read(16'h0000, 16'h1505);
    test_read(16'h00A4, 16'hFFFF);
    test_read(16'h0013, 16'h0000);            // R3 forced bits ignored
    test_short(16'h1200, 16'h0022);
    test_short(16'h00FF, 16'hAB81);
    test_write(2'b00, 16'h0000, 16'h0000);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule